// File: doc/BRIEF.md
# Serial Control Front End for an Eight-Channel 12-Bit Sampling Converter

This block is the digital serial side of a sampling converter. A host talks to it as an SPI-style slave: an active-low select, a serial clock, a data line in and a data line out, plus a strobe. Once select is low the block waits for the first `1` on the data input. That bit opens an eight-bit command. The command chooses an input channel, single-ended or differential measurement, straight binary or two's complement coding, and one of four power/clock modes. The analog core is not part of this block. A parallel result port and a done pulse stand in for it.

Every serial input is brought into the system clock domain through a two-stage synchronizer and handled at its synchronized edges. For the conversion modes, the block raises an acquisition window, pulses a convert request and then shifts the 12-bit result out MSB first on falling serial clock edges. In external-clock mode a frame is 24 serial clocks long. In internal-clock mode the block waits for the core's done pulse, and the host may send the next command while the previous result is still being shifted out. The two power-down codes start no conversion.

Top module: `adc_serial_front`

## Requirements
- R1: Every serial input (`cs_n`, `sclk`, `din`) acts on the third rising `clk` edge after it changes. There are two synchronizer stages and one stage of logic.
- R2: While `cs_n` is low and no command is open, rising `sclk` edges that sample `din`=0 are ignored. The first rising edge that samples `din`=1 is the start bit, which is command bit 7.
- R3: The seven bits after the start bit arrive MSB first: A2, A1, A0, UNI, SGL, PD1, PD0. On the rising edge that samples PD0, `mux_sel` becomes {SGL,A2,A1,A0} and `unipolar` becomes UNI. These two outputs change at no other time.
- R4: `acquire` rises on the rising edge that samples SGL (the 6th command bit). It falls on the next falling `sclk` edge after PD0.
- R5: `convert_start` is a one-cycle pulse. It is issued together with the fall of `acquire`, and only when PD1=1.
- R6: Mode codes {PD1,PD0} are: 00 full power-down, 01 fast power-down, 10 internal clock, 11 external clock. With PD1=0 no conversion starts. `power_down` is 1 and `pd_fast` equals PD0 until the next command completes.
- R7: External mode. The frame spans 24 rising `sclk` edges counted from the start bit. The 9th falling edge loads `core_result` and drives B11. Falling edges 10 to 20 drive B10 down to B0. Later falling edges drive 0. A new start bit is accepted from the 25th rising edge on.
- R8: With UNI=1 the result is sent unchanged (straight binary). With UNI=0 its MSB is inverted, which turns offset binary into two's complement.
- R9: Internal mode. `sstrb` falls one cycle after `convert_start`. It rises one cycle after `core_done` is seen, and that same cycle loads `core_result`. The next 12 falling edges drive B11 down to B0, and further falling edges drive 0.
- R10: Internal mode. While a conversion is busy, rising edges are ignored. After `sstrb` rises, a new command can be shifted in during the readout of the previous result.
- R11: When `cs_n` is high, any open command, pending readout and frame position are discarded and `dout` is 0. `mux_sel`, `unipolar` and the mode outputs keep their last complete values.
- R12: After synchronous reset: `dout`=0, `sstrb`=1, `acquire`=0, `convert_start`=0, `mux_sel`=0, `unipolar`=0, `power_down`=1, `pd_fast`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data, sampled on rising `sclk` |
| core_result | input | 12 | Conversion result from the core, offset binary |
| core_done | input | 1 | One-cycle done pulse from the core in internal mode |
| dout | output | 1 | Serial result, changes on falling `sclk` |
| sstrb | output | 1 | Low while an internal-mode conversion is busy |
| mux_sel | output | 4 | {SGL, A2, A1, A0} of the last complete command |
| unipolar | output | 1 | Coding bit of the last complete command |
| acquire | output | 1 | Acquisition window |
| convert_start | output | 1 | One-cycle conversion request |
| power_down | output | 1 | Last complete command chose a power-down code |
| pd_fast | output | 1 | That power-down code was the fast one |

## Verification
The bench puts the following patterns through the front end:
- Leading zeros before a start bit, which show that start detection ignores bit position.
- Two external frames sent back to back under one select. The first is single-ended and unipolar, the second differential and bipolar. Together they separate the two codings and confirm the 24-clock frame boundary.
- Both power-down codes, and a command cut short by raising select. These show that no conversion starts and that partial commands leave the settings untouched.
- An internal-mode conversion read out while the next command is clocked in. Ones are driven on `din` during the busy time, so a front end that does not ignore them would pick up a false start.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

  typedef enum logic [1:0] {
    PM_FULL_PD = 2'b00,
    PM_FAST_PD = 2'b01,
    PM_INT_CLK = 2'b10,
    PM_EXT_CLK = 2'b11
  } pmode_e;

  typedef struct packed {
    logic [3:0] mux;
    logic       unipolar;
    pmode_e     pmode;
  } cfg_t;

  typedef enum logic [1:0] {
    PS_HUNT,
    PS_BYTE,
    PS_ENDACQ,
    PS_TAIL
  } pstate_e;

endpackage

// File: rtl/adcif_sync.sv
module adcif_sync #(
  parameter int             N       = 3,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic s1, s2, pv;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        pv <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
        pv <= s2;
      end
    end
    assign lvl[i]  = s2;
    assign rise[i] = s2 & ~pv;
    assign fall[i] = ~s2 & pv;
  end

endmodule

// File: rtl/adcif_parser.sv
module adcif_parser
  import adcif_pkg::*;
#(
  parameter int BYTE_BITS  = 8,
  parameter int FRAME_CLKS = 24,
  parameter int ACQ_BIT    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_hi,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic din_s,
  input  logic busy,
  output cfg_t cfg,
  output logic acquire,
  output logic conv_pulse,
  output logic ext_load
);

  localparam int CW = $clog2(FRAME_CLKS + 1);
  localparam int SW = BYTE_BITS - 1;

  pstate_e       state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic [SW-1:0] sh;
  logic [SW-1:0] word;
  logic          need_load;

  assign cnt_nxt = cnt + CW'(1);
  assign word    = {sh[SW-2:0], din_s};
  assign ext_load = (state == PS_TAIL) && need_load && sck_fall && !cs_hi;

  always_ff @(posedge clk) begin
    conv_pulse <= 1'b0;
    if (rst) begin
      state     <= PS_HUNT;
      cnt       <= '0;
      sh        <= '0;
      need_load <= 1'b0;
      acquire   <= 1'b0;
      cfg       <= '{mux: 4'd0, unipolar: 1'b0, pmode: PM_FULL_PD};
    end else if (cs_hi) begin
      state     <= PS_HUNT;
      cnt       <= '0;
      need_load <= 1'b0;
      acquire   <= 1'b0;
    end else begin
      unique case (state)
        PS_HUNT: begin
          if (sck_rise && din_s && !busy) begin
            state <= PS_BYTE;
            cnt   <= CW'(1);
            sh    <= '0;
          end
        end
        PS_BYTE: begin
          if (sck_rise) begin
            sh  <= word;
            cnt <= cnt_nxt;
            if (cnt_nxt == CW'(ACQ_BIT)) acquire <= 1'b1;
            if (cnt_nxt == CW'(BYTE_BITS)) begin
              cfg.mux      <= {word[2], word[6:4]};
              cfg.unipolar <= word[3];
              cfg.pmode    <= pmode_e'(word[1:0]);
              state        <= PS_ENDACQ;
            end
          end
        end
        PS_ENDACQ: begin
          if (sck_fall) begin
            acquire <= 1'b0;
            if (cfg.pmode[1]) conv_pulse <= 1'b1;
            if (cfg.pmode == PM_EXT_CLK) begin
              state     <= PS_TAIL;
              need_load <= 1'b1;
            end else begin
              state <= PS_HUNT;
            end
          end
        end
        PS_TAIL: begin
          if (sck_fall && need_load) need_load <= 1'b0;
          if (sck_rise) begin
            cnt <= cnt_nxt;
            if (cnt_nxt == CW'(FRAME_CLKS)) state <= PS_HUNT;
          end
        end
        default: state <= PS_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/adcif_shifter.sv
module adcif_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld_int,
  input  logic         ld_ext,
  input  logic         shift,
  input  logic [W-1:0] val,
  output logic         dout
);

  localparam int RW = $clog2(W + 1);

  logic [W-1:0]  data;
  logic [RW-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      data   <= '0;
      remain <= '0;
      dout   <= 1'b0;
    end else if (ld_ext) begin
      dout   <= val[W-1];
      data   <= {val[W-2:0], 1'b0};
      remain <= RW'(W - 1);
    end else if (ld_int) begin
      data   <= val;
      remain <= RW'(W);
    end else if (shift) begin
      if (remain != '0) begin
        dout   <= data[W-1];
        data   <= {data[W-2:0], 1'b0};
        remain <= remain - RW'(1);
      end else begin
        dout <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/adc_serial_front.sv
module adc_serial_front
  import adcif_pkg::*;
#(
  parameter int RES_W      = 12,
  parameter int BYTE_BITS  = 8,
  parameter int FRAME_CLKS = 24,
  parameter int ACQ_BIT    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic             din,
  input  logic [RES_W-1:0] core_result,
  input  logic             core_done,
  output logic             dout,
  output logic             sstrb,
  output logic [3:0]       mux_sel,
  output logic             unipolar,
  output logic             acquire,
  output logic             convert_start,
  output logic             power_down,
  output logic             pd_fast
);

  localparam int NSIG = 3;

  logic [NSIG-1:0] raw, lvl, rise, fall;
  logic            cs_hi, sck_r, sck_f, din_s;
  logic            busy, ld_ext, ld_int;
  logic            unused_edges;
  cfg_t            cfg;
  logic [RES_W-1:0] coded;

  assign raw = {din, sclk, cs_n};

  adcif_sync #(.N(NSIG), .RST_VAL(3'b001)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .lvl (lvl),
    .rise(rise),
    .fall(fall)
  );

  assign cs_hi = lvl[0];
  assign sck_r = rise[1];
  assign sck_f = fall[1];
  assign din_s = lvl[2];
  assign unused_edges = ^{rise[0], rise[2], fall[0], fall[2], lvl[1]};

  adcif_parser #(
    .BYTE_BITS (BYTE_BITS),
    .FRAME_CLKS(FRAME_CLKS),
    .ACQ_BIT   (ACQ_BIT)
  ) u_parser (
    .clk       (clk),
    .rst       (rst),
    .cs_hi     (cs_hi),
    .sck_rise  (sck_r),
    .sck_fall  (sck_f),
    .din_s     (din_s),
    .busy      (busy),
    .cfg       (cfg),
    .acquire   (acquire),
    .conv_pulse(convert_start),
    .ext_load  (ld_ext)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sstrb <= 1'b1;
    end else if (convert_start && cfg.pmode == PM_INT_CLK) begin
      busy  <= 1'b1;
      sstrb <= 1'b0;
    end else if (busy && core_done) begin
      busy  <= 1'b0;
      sstrb <= 1'b1;
    end
  end

  assign ld_int = busy && core_done;
  assign coded  = cfg.unipolar ? core_result
                               : {~core_result[RES_W-1], core_result[RES_W-2:0]};

  adcif_shifter #(.W(RES_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .clr   (cs_hi),
    .ld_int(ld_int),
    .ld_ext(ld_ext),
    .shift (sck_f),
    .val   (coded),
    .dout  (dout)
  );

  assign mux_sel    = cfg.mux;
  assign unipolar   = cfg.unipolar;
  assign power_down = ~cfg.pmode[1];
  assign pd_fast    = (cfg.pmode == PM_FAST_PD);

endmodule

// File: rtl/adcif_checker.sv
module adcif_checker (
  input logic       clk,
  input logic       rst,
  input logic       acquire,
  input logic       convert_start,
  input logic       power_down,
  input logic       pd_fast,
  input logic       sstrb,
  input logic [3:0] mux_sel,
  input logic       unipolar
);

  p_conv_single_r5: assert property (@(posedge clk) disable iff (rst)
    convert_start |=> !convert_start);

  p_conv_closes_acq_r4: assert property (@(posedge clk) disable iff (rst)
    convert_start |-> (!acquire && $past(acquire)));

  p_pd_no_conv_r6: assert property (@(posedge clk) disable iff (rst)
    power_down |-> !convert_start);

  p_fast_implies_pd_r6: assert property (@(posedge clk) disable iff (rst)
    pd_fast |-> power_down);

  p_strobe_after_start_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(sstrb) |-> $past(convert_start));

  p_cfg_held_r3: assert property (@(posedge clk) disable iff (rst)
    !acquire |=> ($stable(mux_sel) && $stable(unipolar)));

endmodule

bind adc_serial_front adcif_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .acquire      (acquire),
  .convert_start(convert_start),
  .power_down   (power_down),
  .pd_fast      (pd_fast),
  .sstrb        (sstrb),
  .mux_sel      (mux_sel),
  .unipolar     (unipolar)
);

// File: tb/sim_adc_serial_front.sv
`timescale 1ns/1ps
module sim_adc_serial_front;

  localparam int HALF  = 16;
  localparam int DLY   = 3000;
  localparam int LIMIT = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic [11:0] core_result = 12'h000;
  logic        core_done = 1'b0;
  logic        dout, sstrb, unipolar, acquire, convert_start, power_down, pd_fast;
  logic [3:0]  mux_sel;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 0;
  bit started = 0;

  always #5 clk = ~clk;

  adc_serial_front u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .core_result(core_result), .core_done(core_done),
    .dout(dout), .sstrb(sstrb), .mux_sel(mux_sel), .unipolar(unipolar),
    .acquire(acquire), .convert_start(convert_start),
    .power_down(power_down), .pd_fast(pd_fast)
  );

  task automatic chk(input string req, input string sig,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: %s got %0h expected %0h (t=%0t)", req, sig, got, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // Inputs are seen through two sampling stages (R1); events are acted on
  // at the next edge.
  logic mcs1 = 1'b1, mcs2 = 1'b1;
  logic msc1 = 1'b0, msc2 = 1'b0, mscp = 1'b0;
  logic md1 = 1'b0, md2 = 1'b0;
  int   m_stage = 0, m_pos = 0;
  logic [7:0] m_byte = 8'd0;
  bit   m_need = 0;
  logic [3:0] m_mux = 4'd0;
  logic m_uni = 1'b0;
  logic [1:0] m_pm = 2'b00;
  logic m_acq = 1'b0, m_conv = 1'b0, m_busy = 1'b0, m_sstrb = 1'b1, m_dout = 1'b0;
  bit   m_q[$];

  task automatic m_load(input logic [11:0] v);
    m_q.delete();
    for (int i = 11; i >= 0; i--) m_q.push_back(v[i]);
  endtask

  always @(posedge clk) begin : model
    logic r, f, csh, d, o_conv, o_busy, o_uni;
    logic [1:0] o_pm;
    int o_stage;
    bit o_need;
    logic [11:0] cv;
    r = msc2 && !mscp; f = !msc2 && mscp; csh = mcs2; d = md2;
    o_conv = m_conv; o_busy = m_busy; o_pm = m_pm; o_uni = m_uni;
    o_stage = m_stage; o_need = m_need;
    started = 1;
    if (rst) begin
      m_stage = 0; m_pos = 0; m_byte = 0; m_need = 0;
      m_mux = 0; m_uni = 0; m_pm = 2'b00;          // R12
      m_acq = 0; m_conv = 0; m_busy = 0; m_sstrb = 1; m_dout = 0;
      m_q.delete();
      mcs1 = 1; mcs2 = 1; msc1 = 0; msc2 = 0; mscp = 0; md1 = 0; md2 = 0;
    end else begin
      m_conv = 0;
      if (o_conv && o_pm == 2'b10) begin m_busy = 1; m_sstrb = 0; end       // R9
      else if (o_busy && core_done) begin m_busy = 0; m_sstrb = 1; end
      cv = o_uni ? core_result : (core_result ^ 12'h800);                   // R8
      if (csh) begin m_q.delete(); m_dout = 0; end                          // R11
      else if (o_stage == 3 && o_need && f) begin m_load(cv); m_dout = m_q.pop_front(); end // R7
      else if (o_busy && core_done) m_load(cv);
      else if (f) m_dout = (m_q.size() > 0) ? m_q.pop_front() : 1'b0;
      if (csh) begin m_stage = 0; m_pos = 0; m_acq = 0; m_need = 0; end
      else case (o_stage)
        0: if (r && d && !o_busy) begin m_stage = 1; m_pos = 1; m_byte = 8'd1; end  // R2 R10
        1: if (r) begin
             m_byte = {m_byte[6:0], d}; m_pos++;
             if (m_pos == 6) m_acq = 1;                                      // R4
             if (m_pos == 8) begin
               m_mux = {m_byte[2], m_byte[6:4]}; m_uni = m_byte[3];          // R3
               m_pm = m_byte[1:0]; m_stage = 2;                              // R6
             end
           end
        2: if (f) begin
             m_acq = 0;
             if (o_pm[1]) m_conv = 1;                                        // R5
             if (o_pm == 2'b11) begin m_stage = 3; m_need = 1; end else m_stage = 0;
           end
        3: begin
             if (f) m_need = 0;
             if (r) begin m_pos++; if (m_pos == 24) m_stage = 0; end
           end
        default: m_stage = 0;
      endcase
      mcs2 = mcs1; mcs1 = cs_n;
      mscp = msc2; msc2 = msc1; msc1 = sclk;
      md2 = md1; md1 = din;
    end
  end

  // stand-in core for internal mode
  int cd_cnt = 0;
  always @(negedge clk) begin
    core_done = (cd_cnt == 1);
    if (m_conv && m_pm == 2'b10) cd_cnt = DLY;
    else if (cd_cnt > 0) cd_cnt--;
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R7/R8/R9", "dout", 32'(dout), 32'(m_dout));
      chk("R9", "sstrb", 32'(sstrb), 32'(m_sstrb));
      chk("R1/R3", "mux_sel", 32'(mux_sel), 32'(m_mux));
      chk("R3", "unipolar", 32'(unipolar), 32'(m_uni));
      chk("R4", "acquire", 32'(acquire), 32'(m_acq));
      chk("R5", "convert_start", 32'(convert_start), 32'(m_conv));
      chk("R6", "power_down", 32'(power_down), 32'(!m_pm[1]));
      chk("R6", "pd_fast", 32'(pd_fast), 32'(m_pm == 2'b01));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cyc, LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic run_clocks(input logic [31:0] pat, input int n, output logic [31:0] samp);
    samp = '0;
    for (int i = 0; i < n; i++) begin
      din = pat[n-1-i];
      repeat (HALF) @(negedge clk);
      samp[n-1-i] = dout;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic sel(input logic v);
    repeat (HALF) @(negedge clk);
    cs_n = v;
    repeat (2 * HALF) @(negedge clk);
  endtask

  function automatic logic [11:0] coded(input logic [11:0] v, input logic uni);
    return uni ? v : (v ^ 12'h800);
  endfunction

  initial begin : stim
    logic [31:0] s;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12", "dout", 32'(dout), 0);
    chk("R12", "sstrb", 32'(sstrb), 1);
    chk("R12", "power_down", 32'(power_down), 1);
    chk("R12", "mux_sel", 32'(mux_sel), 0);

    // R2 leading zeros, then external unipolar single-ended frame (R7 R8)
    core_result = 12'hA5C;
    sel(1'b0);
    run_clocks(32'h0, 3, s);
    run_clocks({8'b1_101_1_1_11, 16'h0}, 24, s);
    chk("R7", "ext word unipolar", 32'(s[14:3]), 32'(coded(12'hA5C, 1'b1)));
    chk("R7", "zeros after B0", 32'(s[2:0]), 0);
    chk("R3", "mux_sel ext1", 32'(mux_sel), 32'hD);
    // back-to-back frame, bipolar differential (R7 R8)
    core_result = 12'h123;
    run_clocks({8'b1_010_0_0_11, 16'h0}, 24, s);
    chk("R8", "ext word bipolar", 32'(s[14:3]), 32'(coded(12'h123, 1'b0)));
    chk("R3", "mux_sel ext2", 32'(mux_sel), 32'h2);
    sel(1'b1);

    // fast power-down, with explicit R1 latency check on the last bit
    sel(1'b0);
    run_clocks(32'(7'b1_011_1_1_0), 7, s);
    din = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    @(negedge clk); chk("R1", "mux_sel edge+1", 32'(mux_sel), 32'h2);
    @(negedge clk); chk("R1", "mux_sel edge+2", 32'(mux_sel), 32'h2);
    @(negedge clk); chk("R1", "mux_sel edge+3", 32'(mux_sel), 32'hB);
    repeat (HALF - 3) @(negedge clk);
    sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    sel(1'b1);
    chk("R6", "pd_fast", 32'(pd_fast), 1);
    chk("R6", "power_down", 32'(power_down), 1);

    // R11 abort mid-command
    sel(1'b0);
    run_clocks(32'(5'b1_111_0), 5, s);
    sel(1'b1);
    chk("R11", "mux_sel kept", 32'(mux_sel), 32'hB);
    chk("R11", "acquire cleared", 32'(acquire), 0);
    chk("R11", "dout idle", 32'(dout), 0);

    // full power-down
    sel(1'b0);
    run_clocks(32'(8'b1_000_1_1_00), 8, s);
    sel(1'b1);
    chk("R6", "full pd_fast", 32'(pd_fast), 0);
    chk("R6", "full mux", 32'(mux_sel), 32'h8);

    // internal mode with interleaved next command (R9 R10)
    core_result = 12'h3C7;
    sel(1'b0);
    run_clocks(32'(8'b1_110_1_1_10), 8, s);
    repeat (8) @(negedge clk);
    chk("R9", "sstrb busy", 32'(sstrb), 0);
    repeat (DLY + 100) @(negedge clk);
    chk("R9", "sstrb done", 32'(sstrb), 1);
    core_result = 12'h0F0;
    run_clocks({8'b1_001_0_0_10, 8'hFF}, 16, s);
    chk("R9", "int word 1", 32'(s[14:3]), 32'(coded(12'h3C7, 1'b1)));
    chk("R10", "interleaved mux", 32'(mux_sel), 32'h1);
    repeat (DLY + 100) @(negedge clk);
    run_clocks(32'h0, 16, s);
    chk("R10", "int word 2 bipolar", 32'(s[14:3]), 32'(coded(12'h0F0, 1'b0)));
    chk("R9", "zeros after B0", 32'(s[2:0]), 0);
    sel(1'b1);

    repeat (20) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule